// File: doc/BRIEF.md
# Synchronous Sync-Character Hunt and Word Framer

This block frames characters for a synchronous serial receiver. While it is hunting, every received bit is shifted in and the most recent window of bits is compared with a programmable sync character. No word boundaries exist during the hunt. When the window matches, the block declares sync and raises a one-cycle interrupt. From then on it counts bits in groups of the configured word length and hands each complete word to the receive buffer with a load strobe.

Software controls framing through a found/search bit. Writing it clears sync and restarts the hunt, or forces framing to begin at once. After sync, a match flag shows whether the most recently completed word equalled the sync character. When stripping is enabled, words equal to the sync character are dropped and produce no load strobe. Dropping receiver-enable returns the block to the hunt and clears its flags.

Top module: `sync_hunt_rx`

## Requirements
- R1: After synchronous reset, `found`, `match_flag`, `word_ld` and `sync_irq` are all 0.
- R2: The word length L is 5 + `word_len` (codes 0..3 give 5..8 bits). Bits arrive LSB first, one per `bit_stb`. Only the low L bits of `sync_char` take part in any comparison.
- R3: While `found` is 0, each strobe compares the last L received bits with the sync character. Only strobes that come at least L bits after the hunt started count. On a match, `found` goes to 1 and `sync_irq` pulses for one cycle, both in the cycle after the strobe. The matching bits are never loaded.
- R4: While `found` is 0, `word_ld` never asserts, whatever bits arrive.
- R5: While `found` is 1, every L-th strobe completes a word. In the cycle after that strobe, `word_ld` pulses for one cycle. `word_out` then holds the word with its first-received bit in bit 0, and bits above L-1 are zero.
- R6: At each completed word, `match_flag` becomes 1 if the word equals the low L bits of `sync_char`, and 0 otherwise. It holds its value between words.
- R7: With `strip_en` at 1, a completed word equal to the sync character gives no `word_ld`, but `match_flag` still sets.
- R8: A cycle with `fs_wr` at 1 loads `found` from `fs_wdata` and restarts the bit count, so a new word or hunt window starts at the next strobe. Writing 0 enters the hunt.
- R9: While `rx_en` is 0, `found` and `match_flag` are 0, strobes are ignored, and no `word_ld` or `sync_irq` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rx_bit | input | 1 | Serial data bit |
| bit_stb | input | 1 | One-cycle strobe marking `rx_bit` valid |
| sync_char | input | DW | Sync character |
| word_len | input | LCW | Word length code, L = 5 + code |
| strip_en | input | 1 | Drop words equal to the sync character |
| fs_wr | input | 1 | Write strobe for the found/search bit |
| fs_wdata | input | 1 | Value written to the found/search bit |
| word_out | output | DW | Last framed word, right-aligned |
| word_ld | output | 1 | One-cycle load strobe for `word_out` |
| found | output | 1 | Found/search status: 1 framed, 0 hunting |
| match_flag | output | 1 | Last completed word equalled the sync character |
| sync_irq | output | 1 | One-cycle pulse when sync is found by the hunt |

## Verification
A bit counter that is off by one shows up at the ports within one word time. Every later word arrives shifted by a bit, and the scoreboard's word comparison catches it on the next load strobe. A hunt that matches on a stale or partial window raises `sync_irq` early. The same fault makes the words that follow misaligned, and both show in the first word after sync. A match flag or strip decision fed by the wrong comparison shows as a wrong flag, or as a missing or extra load, in the cycle after the word's final strobe.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  typedef enum logic {
    MODE_HUNT  = 1'b0,
    MODE_FRAME = 1'b1
  } hunt_mode_e;

  // Word length in bits from the length code.
  function automatic int unsigned len_from_code(input int unsigned code,
                                                input int unsigned min_len);
    return min_len + code;
  endfunction

endpackage

// File: rtl/sync_hunt_shift.sv
module sync_hunt_shift #(
  parameter int unsigned DW   = 8,
  parameter int unsigned LENW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  input  logic [LENW-1:0] len,
  output logic [DW-1:0]   win_nxt
);
  logic [DW-1:0] sr_q;
  logic [DW-1:0] sr_nxt;
  logic [LENW-1:0] drop;

  // New bits enter at the top, so the oldest bit of the last L sits at DW-L.
  assign sr_nxt  = {din, sr_q[DW-1:1]};
  assign drop    = LENW'(DW) - len;
  assign win_nxt = sr_nxt >> drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= sr_nxt;
    end
  end
endmodule

// File: rtl/sync_hunt_cmp.sv
module sync_hunt_cmp #(
  parameter int unsigned DW   = 8,
  parameter int unsigned LENW = 4
) (
  input  logic [DW-1:0]   win,
  input  logic [DW-1:0]   pattern,
  input  logic [LENW-1:0] len,
  output logic            eq
);
  logic [DW-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < DW; i++) begin
      mask[i] = (LENW'(i) < len);
    end
    eq = (((win ^ pattern) & mask) == '0);
  end
endmodule

// File: rtl/sync_hunt_ctl.sv
module sync_hunt_ctl
  import sync_hunt_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned LENW = 4,
  parameter int unsigned CNTW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_en,
  input  logic            bit_stb,
  input  logic            strip_en,
  input  logic            fs_wr,
  input  logic            fs_wdata,
  input  logic            eq,
  input  logic [DW-1:0]   win,
  input  logic [LENW-1:0] len,
  output logic            found,
  output logic            match_flag,
  output logic            word_ld,
  output logic [DW-1:0]   word_out,
  output logic            sync_irq
);
  hunt_mode_e     mode_q;
  logic [CNTW-1:0] cnt_q;
  logic            at_limit;

  // In the hunt the counter saturates at L-1 (window full);
  // while framing it marks the last bit of a word.
  assign at_limit = ({{(LENW > CNTW ? LENW-CNTW : 1){1'b0}}, cnt_q} == (len - 1'b1));
  assign found    = (mode_q == MODE_FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_HUNT;
      cnt_q      <= '0;
      match_flag <= 1'b0;
      word_ld    <= 1'b0;
      word_out   <= '0;
      sync_irq   <= 1'b0;
    end else begin
      word_ld  <= 1'b0;
      sync_irq <= 1'b0;
      if (!rx_en) begin
        mode_q     <= MODE_HUNT;
        cnt_q      <= '0;
        match_flag <= 1'b0;
      end else if (fs_wr) begin
        mode_q <= fs_wdata ? MODE_FRAME : MODE_HUNT;
        cnt_q  <= '0;
      end else if (bit_stb) begin
        if (mode_q == MODE_HUNT) begin
          if (at_limit && eq) begin
            mode_q   <= MODE_FRAME;
            sync_irq <= 1'b1;
            cnt_q    <= '0;
          end else if (!at_limit) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (at_limit) begin
            cnt_q      <= '0;
            match_flag <= eq;
            if (!(strip_en && eq)) begin
              word_ld  <= 1'b1;
              word_out <= win;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import sync_hunt_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned MIN_LEN = 5,
  parameter int unsigned LCW     = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_en,
  input  logic           rx_bit,
  input  logic           bit_stb,
  input  logic [DW-1:0]  sync_char,
  input  logic [LCW-1:0] word_len,
  input  logic           strip_en,
  input  logic           fs_wr,
  input  logic           fs_wdata,
  output logic [DW-1:0]  word_out,
  output logic           word_ld,
  output logic           found,
  output logic           match_flag,
  output logic           sync_irq
);
  localparam int unsigned LENW = $clog2(DW + 1);
  localparam int unsigned CNTW = (DW > 1) ? $clog2(DW) : 1;

  logic [LENW-1:0] len;
  logic [DW-1:0]   win;
  logic            eq;
  logic            shift_en;

  assign len      = LENW'(len_from_code(32'(word_len), MIN_LEN));
  assign shift_en = rx_en && bit_stb && !fs_wr;

  sync_hunt_shift #(.DW(DW), .LENW(LENW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shift_en),
    .din     (rx_bit),
    .len     (len),
    .win_nxt (win)
  );

  sync_hunt_cmp #(.DW(DW), .LENW(LENW)) u_cmp (
    .win    (win),
    .pattern(sync_char),
    .len    (len),
    .eq     (eq)
  );

  sync_hunt_ctl #(.DW(DW), .LENW(LENW), .CNTW(CNTW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .bit_stb   (bit_stb),
    .strip_en  (strip_en),
    .fs_wr     (fs_wr),
    .fs_wdata  (fs_wdata),
    .eq        (eq),
    .win       (win),
    .len       (len),
    .found     (found),
    .match_flag(match_flag),
    .word_ld   (word_ld),
    .word_out  (word_out),
    .sync_irq  (sync_irq)
  );
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk #(
  parameter int unsigned DW  = 8,
  parameter int unsigned LCW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           rx_en,
  input logic           rx_bit,
  input logic           bit_stb,
  input logic [DW-1:0]  sync_char,
  input logic [LCW-1:0] word_len,
  input logic           strip_en,
  input logic           fs_wr,
  input logic           fs_wdata,
  input logic [DW-1:0]  word_out,
  input logic           word_ld,
  input logic           found,
  input logic           match_flag,
  input logic           sync_irq
);
  assert_irq_on_entry_R3: assert property (@(posedge clk) disable iff (rst)
    sync_irq |-> (found && !$past(found)));

  assert_exclusive_pulses_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({word_ld, sync_irq}));

  assert_load_needs_frame_R5: assert property (@(posedge clk) disable iff (rst)
    word_ld |-> ($past(found) && $past(bit_stb)));

  assert_strip_blocks_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (word_ld && $past(strip_en)) |-> !match_flag);

  assert_sw_write_R8: assert property (@(posedge clk) disable iff (rst)
    (fs_wr && rx_en) |=> (found == $past(fs_wdata)));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!found && !match_flag && !word_ld && !sync_irq));
endmodule

bind sync_hunt_rx sync_hunt_chk #(.DW(DW), .LCW(LCW)) u_chk (.*);

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       rx_bit = 1'b0;
  logic       bit_stb = 1'b0;
  logic [7:0] sync_char = 8'h00;
  logic [1:0] word_len = 2'd3;
  logic       strip_en = 1'b0;
  logic       fs_wr = 1'b0;
  logic       fs_wdata = 1'b0;
  logic [7:0] word_out;
  logic       word_ld;
  logic       found;
  logic       match_flag;
  logic       sync_irq;

  int errors = 0;
  int checks = 0;
  int irq_seen = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  sync_hunt_rx u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit), .bit_stb(bit_stb),
    .sync_char(sync_char), .word_len(word_len), .strip_en(strip_en),
    .fs_wr(fs_wr), .fs_wdata(fs_wdata), .word_out(word_out), .word_ld(word_ld),
    .found(found), .match_flag(match_flag), .sync_irq(sync_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected words as loads appear (R5, R4, R7).
  always @(negedge clk) begin
    if (!rst && word_ld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R7 unexpected word_ld", int'(word_out), 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(word_out == e, "R5 word_out", int'(word_out), int'(e));
      end
    end
    if (!rst && sync_irq) irq_seen++;
  end

  task automatic put_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) put_bit(v[i]);
    @(negedge clk);
  endtask

  task automatic sw_fs(input logic v);
    @(negedge clk);
    fs_wr = 1'b1;
    fs_wdata = v;
    @(negedge clk);
    fs_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(found == 1'b0 && match_flag == 1'b0 && word_ld == 1'b0 && sync_irq == 1'b0,
        "R1 reset state", int'({found, match_flag, word_ld, sync_irq}), 0);
    rst = 1'b0;
    rx_en = 1'b1;
    sync_char = 8'h16;
    word_len = 2'd3;

    // Hunt, length 8: zeros then sync; no load during the hunt (R4)
    send_word(8'h00, 8);
    chk(found == 1'b0, "R4 still hunting", int'(found), 0);
    chk(irq_seen == 0, "R3 no early irq", irq_seen, 0);
    send_word(8'h16, 8);
    chk(found == 1'b1, "R3 found after sync", int'(found), 1);
    chk(irq_seen == 1, "R3 one irq", irq_seen, 1);

    // Framing (R5, R6)
    exp_q.push_back(8'hA5);
    send_word(8'hA5, 8);
    chk(match_flag == 1'b0, "R6 no match on A5", int'(match_flag), 0);
    exp_q.push_back(8'h16);
    send_word(8'h16, 8);
    chk(match_flag == 1'b1, "R6 match on sync word", int'(match_flag), 1);

    // Strip (R7)
    strip_en = 1'b1;
    send_word(8'h16, 8);
    chk(match_flag == 1'b1, "R7 match set on stripped word", int'(match_flag), 1);
    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    exp_q.push_back(8'h77);
    send_word(8'h77, 8);
    chk(match_flag == 1'b0, "R6 match cleared", int'(match_flag), 0);
    strip_en = 1'b0;

    // Software clear enters the hunt (R8); length 5 with upper sync bits set (R2)
    sw_fs(1'b0);
    chk(found == 1'b0, "R8 cleared to hunt", int'(found), 0);
    word_len = 2'd0;
    sync_char = 8'hEB;
    send_word(8'h00, 5);
    chk(found == 1'b0, "R2 no match on zeros", int'(found), 0);
    send_word(8'h0B, 5);
    chk(found == 1'b1, "R2 masked 5-bit sync found", int'(found), 1);
    chk(irq_seen == 2, "R3 second irq", irq_seen, 2);
    exp_q.push_back(8'h15);
    send_word(8'h15, 5);
    chk(match_flag == 1'b0, "R6 5-bit non-match", int'(match_flag), 0);
    exp_q.push_back(8'h0B);
    send_word(8'h0B, 5);
    chk(match_flag == 1'b1, "R2 masked compare match", int'(match_flag), 1);

    // Receiver disabled (R9)
    rx_en = 1'b0;
    @(negedge clk);
    chk(found == 1'b0 && match_flag == 1'b0, "R9 flags cleared",
        int'({found, match_flag}), 0);
    send_word(8'h0B, 5);
    send_word(8'h0B, 5);
    chk(found == 1'b0, "R9 strobes ignored", int'(found), 0);
    chk(irq_seen == 2, "R9 no irq while disabled", irq_seen, 2);
    rx_en = 1'b1;
    @(negedge clk);
    chk(found == 1'b0, "R9 re-enable stays in hunt", int'(found), 0);

    // Software force to framing (R8), then length 7
    put_bit(1'b1);
    put_bit(1'b1);
    sw_fs(1'b1);
    chk(found == 1'b1, "R8 forced found", int'(found), 1);
    exp_q.push_back(8'h12);
    send_word(8'h12, 5);
    word_len = 2'd2;
    exp_q.push_back(8'h55);
    send_word(8'h55, 7);
    chk(match_flag == 1'b0, "R6 7-bit non-match", int'(match_flag), 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all expected words seen", exp_q.size(), 0);
    chk(irq_seen == 2, "R3 total irq count", irq_seen, 2);
    finish_run();
  end
endmodule